// File: doc/BRIEF.md
# Two-way set-associative cache tag directory

This block is the directory half of a two-way set-associative cache. For every line slot it stores a tag, a valid bit and a dirty bit, and it stores one replacement bit per set. A single request port takes four kinds of operation. A lookup reports hit or miss, and on a miss it names the way a fill would take. A fill records a new tag once the line data has arrived. An invalidate is driven by snooping and drops a line that another bus master has changed. A flush walks the whole directory and asks, one line at a time, for each modified line to be written back to main memory.

The byte address is split into three fields: the offset within a line, the set index and the tag. Because each set holds two lines, the index is one bit narrower than in a direct-mapped cache with the same capacity, and the tag is one bit wider. When a line is allocated, a free way is used first. The replacement bit is consulted only when both ways already hold valid lines. After reset the block clears its directory one set per cycle and refuses requests until that sweep ends. While a flush is running it also refuses requests.

Top module: `cache_dir2w`

## Requirements
- R1: The address fields are: offset = addr[OFFS_W-1:0], where OFFS_W = log2(LINE_BYTES); index = the next IDX_W bits, where IDX_W = log2(SETS); tag = the remaining upper bits. The offset bits have no effect on any result.
- R2: After reset is released, `busy` stays high for exactly SETS cycles while every set is cleared. A request presented while `busy` is high gets no response and changes no state. After the sweep, every lookup misses.
- R3: `req_op` is encoded as 0 = lookup, 1 = fill, 2 = invalidate and 3 = flush. A request is accepted in a cycle where `req_valid` is high and `busy` is low. For a lookup, fill or invalidate, `rsp_valid` is high in the following cycle. For a lookup, `rsp_hit` is 1 when a valid way holds the tag, and `rsp_way` then gives that way.
- R4: On a lookup miss, `rsp_way` gives the victim way. An invalid way is chosen before a valid one, and way 0 is chosen when both ways are invalid.
- R5: On a lookup miss with both ways valid, the victim is the way named by the set's replacement bit. Every lookup hit and every fill sets that bit to the other way of the set.
- R6: A fill stores the tag, sets the line valid and sets its dirty bit to `req_write`. It uses the way that already holds the tag if there is one; otherwise it uses the victim chosen as in R4 and R5. `rsp_way` reports the way used, and `rsp_hit` reports whether the tag was already present.
- R7: A lookup hit with `req_write` = 1 marks the line dirty.
- R8: An invalidate clears the valid and dirty bits of the line that holds the tag. `rsp_hit` reports whether the line was present, and `rsp_way` is meaningful only when it was. An invalidate of an absent address changes nothing.
- R9: A flush keeps `busy` high and visits each set in ascending index order, way 0 before way 1. For each dirty line it raises `wb_valid` with `wb_addr` = {tag, index, zero offset}. It holds `wb_valid` and `wb_addr` until `wb_ready` is high, then clears that line's dirty bit. Lines stay valid after a flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Operation code (see R3) |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | Lookup: write access; fill: install the line as dirty |
| busy | output | 1 | Reset sweep or flush in progress; requests are refused |
| rsp_valid | output | 1 | Response for the request accepted in the previous cycle |
| rsp_hit | output | 1 | Tag was present |
| rsp_way | output | 1 | Hit way, victim way or filled way |
| wb_valid | output | 1 | Write-back request during a flush |
| wb_addr | output | ADDR_W | Line address to write back |
| wb_ready | input | 1 | Write-back request taken |

## Verification
A lookup, fill or invalidate result is registered, so the response for a request accepted at one clock edge appears after that edge. The bench drives each request on a falling edge, withdraws it on the next falling edge and samples the response at that same moment. The reset sweep is measured by counting the falling edges with `busy` high, starting at the release of reset. During a flush, `wb_valid` and `wb_addr` are combinational from the walk position, so the bench checks them on each falling edge. It holds `wb_ready` back for a varying number of cycles to confirm that the request stays unchanged while it waits.

// File: rtl/cdir_pkg.sv
package cdir_pkg;
  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_FILL   = 2'd1,
    OP_INVAL  = 2'd2,
    OP_FLUSH  = 2'd3
  } cdir_op_e;

  typedef enum logic [1:0] {
    ST_SWEEP = 2'd0,
    ST_IDLE  = 2'd1,
    ST_WALK  = 2'd2
  } cdir_state_e;
endpackage

// File: rtl/cdir_match.sv
module cdir_match
  import cdir_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0]            way_vld,
  input  logic [TAG_W-1:0]           look_tag,
  output logic [WAYS-1:0]            hit_vec
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_vec[w] = way_vld[w] && (way_tag[w] == look_tag);
  end
endmodule

// File: rtl/cdir_victim.sv
module cdir_victim
  import cdir_pkg::*;
(
  input  logic [WAYS-1:0] way_vld,
  input  logic            lru_bit,
  output logic            victim
);
  always_comb begin
    if (!way_vld[0])      victim = 1'b0;
    else if (!way_vld[1]) victim = 1'b1;
    else                  victim = lru_bit;
  end
endmodule

// File: rtl/cdir_ctrl.sv
module cdir_ctrl
  import cdir_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_start,
  input  logic             cur_dirty,
  input  logic             wb_ready,
  output logic             busy,
  output logic             sweeping,
  output logic             walking,
  output logic [IDX_W-1:0] cnt_idx,
  output logic             cnt_way
);
  localparam int CW = IDX_W + 1;

  cdir_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          step;

  assign sweeping = (state_q == ST_SWEEP);
  assign walking  = (state_q == ST_WALK);
  assign busy     = (state_q != ST_IDLE);
  assign cnt_idx  = cnt_q[CW-1:1];
  assign cnt_way  = cnt_q[0];
  assign step     = walking && (!cur_dirty || wb_ready);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_SWEEP: begin
        cnt_d = cnt_q + CW'(2);
        if (&cnt_q[CW-1:1]) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end
      end
      ST_IDLE: begin
        if (flush_start) begin
          state_d = ST_WALK;
          cnt_d   = '0;
        end
      end
      ST_WALK: begin
        if (step) begin
          cnt_d = cnt_q + CW'(1);
          if (&cnt_q) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SWEEP;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // R9: a pending write-back freezes the walk position
  p_wb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (walking && cur_dirty && !wb_ready) |=> (walking && $stable(cnt_q)));
endmodule

// File: rtl/cache_dir2w.sv
module cache_dir2w
  import cdir_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_way,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  input  logic              wb_ready
);
  localparam int OFFS_W = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFFS_W;

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  dty_q [SETS];
  logic             lru_q [SETS];

  logic [TAG_W-1:0]            req_tag;
  logic [IDX_W-1:0]            req_idx;
  logic [WAYS-1:0][TAG_W-1:0]  set_tag;
  logic [WAYS-1:0]             hit_vec;
  logic                        hit, hit_way, vic_way, fill_way;
  logic                        accept, flush_start, sweeping, walking;
  logic [IDX_W-1:0]            cnt_idx;
  logic                        cnt_way, cur_dirty;
  cdir_op_e                    op;
  logic                        rsp_valid_d, rsp_hit_d, rsp_way_d;
  logic                        unused_offset;

  assign req_tag       = req_addr[ADDR_W-1 -: TAG_W];
  assign req_idx       = req_addr[OFFS_W +: IDX_W];
  assign unused_offset = ^req_addr[OFFS_W-1:0];
  assign op            = cdir_op_e'(req_op);
  assign accept        = req_valid && !busy;
  assign flush_start   = accept && (op == OP_FLUSH);

  for (genvar w = 0; w < WAYS; w++) begin : g_set_tag
    assign set_tag[w] = tag_q[req_idx][w];
  end

  cdir_match #(.TAG_W(TAG_W)) u_match (
    .way_tag (set_tag),
    .way_vld (vld_q[req_idx]),
    .look_tag(req_tag),
    .hit_vec (hit_vec)
  );

  cdir_victim u_victim (
    .way_vld(vld_q[req_idx]),
    .lru_bit(lru_q[req_idx]),
    .victim (vic_way)
  );

  assign hit      = |hit_vec;
  assign hit_way  = hit_vec[1];
  assign fill_way = hit ? hit_way : vic_way;

  assign cur_dirty = dty_q[cnt_idx][cnt_way];
  assign wb_valid  = walking && cur_dirty;
  assign wb_addr   = {tag_q[cnt_idx][cnt_way], cnt_idx, {OFFS_W{1'b0}}};

  cdir_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_start(flush_start),
    .cur_dirty  (cur_dirty),
    .wb_ready   (wb_ready),
    .busy       (busy),
    .sweeping   (sweeping),
    .walking    (walking),
    .cnt_idx    (cnt_idx),
    .cnt_way    (cnt_way)
  );

  // Directory storage: cleared by the post-reset sweep, not by reset
  always_ff @(posedge clk) begin
    if (sweeping) begin
      vld_q[cnt_idx] <= '0;
      dty_q[cnt_idx] <= '0;
      lru_q[cnt_idx] <= 1'b0;
    end else if (accept) begin
      case (op)
        OP_LOOKUP: begin
          if (hit) begin
            lru_q[req_idx] <= ~hit_way;
            if (req_write) dty_q[req_idx][hit_way] <= 1'b1;
          end
        end
        OP_FILL: begin
          tag_q[req_idx][fill_way] <= req_tag;
          vld_q[req_idx][fill_way] <= 1'b1;
          dty_q[req_idx][fill_way] <= req_write;
          lru_q[req_idx]           <= ~fill_way;
        end
        OP_INVAL: begin
          if (hit) begin
            vld_q[req_idx][hit_way] <= 1'b0;
            dty_q[req_idx][hit_way] <= 1'b0;
          end
        end
        default: ;
      endcase
    end else if (wb_valid && wb_ready) begin
      dty_q[cnt_idx][cnt_way] <= 1'b0;
    end
  end

  always_comb begin
    rsp_valid_d = accept && (op != OP_FLUSH);
    rsp_hit_d   = hit;
    case (op)
      OP_LOOKUP: rsp_way_d = hit ? hit_way : vic_way;
      OP_FILL:   rsp_way_d = fill_way;
      default:   rsp_way_d = hit_way;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= 1'b0;
    end else begin
      rsp_valid <= rsp_valid_d;
      if (rsp_valid_d) begin
        rsp_hit <= rsp_hit_d;
        rsp_way <= rsp_way_d;
      end
    end
  end

  // R3: a response only follows an accepted non-flush request
  p_rsp_follows_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !busy && (req_op != 2'd3)));

  // R3: at most one way of a set may match a tag
  p_hit_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> $onehot0(hit_vec));

  // R6: the way chosen for a fill is valid afterwards
  p_fill_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op == OP_FILL)) |=> vld_q[$past(req_idx)][$past(fill_way)]);

  // R9: write-back requests only appear while busy
  p_wb_when_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (busy && !rsp_valid_d));
endmodule

// File: tb/cache_dir2w_tb.sv
module cache_dir2w_tb;
  localparam int ADDR_W = 12;
  localparam int LINE_B = 16;
  localparam int SETS   = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_write, wb_ready;
  logic [1:0]        req_op;
  logic [ADDR_W-1:0] req_addr;
  logic              busy, rsp_valid, rsp_hit, rsp_way, wb_valid;
  logic [ADDR_W-1:0] wb_addr;

  int checks = 0;
  int errors = 0;

  int m_tag [SETS][2];
  bit m_v   [SETS][2];
  bit m_d   [SETS][2];
  bit m_lru [SETS];

  always #10 clk = ~clk;

  cache_dir2w #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_B), .SETS(SETS)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_write(req_write), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_ready(wb_ready)
  );

  function automatic int mk(int tag, int set, int off);
    return (tag << 6) | (set << 4) | off;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_op(int op, int tag, int set, int off, bit wr, string lbl);
    bit mh;
    int mw, vic, ew;
    string l;
    mh = 0; mw = 0;
    for (int w = 0; w < 2; w++)
      if (m_v[set][w] && m_tag[set][w] == tag) begin mh = 1; mw = w; end
    vic = !m_v[set][0] ? 0 : (!m_v[set][1] ? 1 : int'(m_lru[set]));
    ew  = mh ? mw : vic;
    l = lbl;
    if (l == "") begin
      if (op == 0) l = mh ? "R3" : ((m_v[set][0] && m_v[set][1]) ? "R5" : "R4");
      else if (op == 1) l = "R6";
      else l = "R8";
    end
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_addr = ADDR_W'(mk(tag, set, off));
    req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    if (op != 3) begin
      chk(l, "rsp_valid", int'(rsp_valid), 1);
      chk(l, "rsp_hit", int'(rsp_hit), int'(mh));
      if (op != 2 || mh) chk(l, "rsp_way", int'(rsp_way), ew);
    end
    case (op)
      0: if (mh) begin m_lru[set] = !mw[0]; if (wr) m_d[set][mw] = 1; end
      1: begin
        m_tag[set][ew] = tag; m_v[set][ew] = 1; m_d[set][ew] = wr;
        m_lru[set] = !ew[0];
      end
      2: if (mh) begin m_v[set][mw] = 0; m_d[set][mw] = 0; end
      default: ;
    endcase
  endtask

  task automatic run_flush();
    int exp_a [8];
    int n, k, guard;
    n = 0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < 2; w++)
        if (m_d[s][w]) begin exp_a[n] = mk(m_tag[s][w], s, 0); n++; end
    do_op(3, 0, 0, 0, 1'b0, "R9");
    chk("R9", "busy during flush", int'(busy), 1);
    k = 0; guard = 0;
    while (busy && guard < 200) begin
      guard++;
      if (wb_valid) begin
        if (k < n) chk("R7/R9", "wb_addr", int'(wb_addr), exp_a[k]);
        repeat (k % 3) @(negedge clk);
        chk("R9", "wb_valid held", int'(wb_valid), 1);
        if (k < n) chk("R9", "wb_addr held", int'(wb_addr), exp_a[k]);
        wb_ready = 1'b1;
        @(negedge clk);
        wb_ready = 1'b0;
        k++;
      end else begin
        @(negedge clk);
      end
    end
    chk("R9", "write-back count", k, n);
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < 2; w++) m_d[s][w] = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    bit stray;
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_addr = '0;
    req_write = 1'b0; wb_ready = 1'b0;
    for (int s = 0; s < SETS; s++) begin
      m_lru[s] = 0;
      for (int w = 0; w < 2; w++) begin m_v[s][w] = 0; m_d[s][w] = 0; m_tag[s][w] = 0; end
    end
    repeat (3) @(negedge clk);
    chk("R2", "rsp_valid in reset", int'(rsp_valid), 0);
    chk("R2", "wb_valid in reset", int'(wb_valid), 0);
    // release and offer a fill that must be refused during the sweep
    rst_n = 1'b1;
    req_valid = 1'b1; req_op = 2'd1; req_addr = ADDR_W'(mk(5, 1, 0)); req_write = 1'b1;
    n = 0; stray = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
      if (rsp_valid) stray = 1;
    end
    req_valid = 1'b0;
    chk("R2", "sweep length", n, SETS);
    chk("R2", "no response while busy", int'(stray), 0);
    @(negedge clk);
    chk("R2", "no late response", int'(rsp_valid), 0);
    do_op(0, 5, 1, 0, 1'b0, "R2");

    for (int s = 0; s < SETS; s++) begin
      int ta, tb, tc;
      ta = s + 1; tb = s + 9; tc = s + 17;
      do_op(0, ta, s, 0, 1'b0, "");
      do_op(1, ta, s, 0, 1'b0, "");
      do_op(0, ta, s, 5, 1'b0, "R1");
      do_op(0, ta, s, 15, 1'b0, "R1");
      do_op(0, tb, s, 3, 1'b0, "");
      do_op(1, tb, s, 0, s[0], "");
      do_op(0, ta, s, 0, 1'b1, "R7");
      do_op(0, tc, s, 0, 1'b0, "R5");
      do_op(1, tc, s, 0, s == 3, "");
      do_op(0, tb, s, 0, 1'b0, "");
      do_op(0, tc, s, 8, 1'b0, "");
      if (s == 2) do_op(2, ta, s, 0, 1'b0, "R8");
      do_op(2, tb, s, 0, 1'b0, "R8");
      do_op(0, ta, s, 0, 1'b0, "");
    end
    // refill an existing tag in place
    do_op(1, 1, 0, 0, 1'b1, "R6");

    run_flush();
    run_flush();
    do_op(0, 1, 0, 0, 1'b0, "R9");
    do_op(0, 20, 3, 0, 1'b0, "R9");
    // invalidate then confirm both ways are vacant again in set 2
    do_op(2, 19, 2, 0, 1'b0, "R8");
    do_op(0, 30, 2, 0, 1'b0, "R4");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule